// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block is a small hardware engine that works out what kind of parallel NOR flash bank hangs off a simple memory bus. A one-cycle `start` pulse makes it issue a single three-write autoselect sequence. Devices of the unlock-cycle command family need all three writes. Devices of the status-register command family react only to the last one. The engine then waits a fixed time, measured in clock cycles, and reads two words. The low byte of word 0 names the manufacturer and so selects the command family. Word 1 is the device code, and it selects the device type.

The detected type sets the sector count and the total bank size, scaled by the number of 16-bit devices that sit side by side on the bus word. It also sets a sector start-address map. That map has eight small boot sectors at the bottom for boot-block devices and equal sectors for the uniform device. A combinational lookup port turns a sector index into its start address. When the part is known, the engine writes the read-mode command of the detected family. It then pulses `done`, and the result outputs hold their values until the next start.

Top module: `nor_id_probe`

## Requirements
- R1: After `start` the engine writes, in three consecutive cycles, 0xAA to word address 0x555, then 0x55 to 0x2AA, then 0x90 to 0x555. Each command byte sits in the low byte of every 16-bit lane of the bus word, and the upper byte of each lane is zero.
- R2: The first read, at word address 0, is strobed exactly WAIT_CYC+1 cycles after the cycle of the 0x90 write, with WAIT_CYC = (CLK_HZ/1000000)*WAIT_US. No bus strobe occurs between the two. Read data must be valid in the cycle after the read strobe.
- R3: Only bits 7:0 of word 0 are decoded. 0x01 gives family 1 (unlock-cycle), 0x89 gives family 2 (status-register), and anything else is unknown (family 0).
- R4: The word at address 1 matches a device code only when every 16-bit lane holds that code. The type codes are: 0x22D7 → 1 (uniform), 0x88C1 → 2, 0x88C3 → 3, 0x88C5 → 4, 0x88CD → 5, 0x8892 → 6, 0x8894 → 7, 0x8896 → 8, 0x8898 → 9 (types 2 to 9 are bottom-boot). The type does not depend on the family.
- R5: An unknown manufacturer or device code gives family 0, type 0, size 0 and sector count 0, and no read-mode write is issued.
- R6: The sector count and size in MiB on a 16-bit port follow the type: type 1 has 128 sectors and 8 MiB. Types 2 and 6 have 23 and 1. Types 3 and 7 have 39 and 2. Types 4 and 8 have 71 and 4. Types 5 and 9 have 135 and 8. The byte size is multiplied by DATA_W/16.
- R7: With L = DATA_W/16, a bottom-boot sector i < 8 starts at BANK_BASE + i·0x2000·L. A bottom-boot sector i ≥ 8 starts at BANK_BASE + (i−7)·0x10000·L. Uniform sector i starts at BANK_BASE + i·0x10000·L. An index at or above the sector count reads 0.
- R8: For a known part the engine makes exactly one more write, to word address 0: 0x00F0 per lane for family 1 and 0x00FF per lane for family 2.
- R9: `done` is high for exactly one cycle, the cycle after the read-mode write (or after the device-code capture when the part is unknown). The results are valid when `done` rises and stay unchanged until the next accepted start, which clears them to 0.
- R10: A `start` pulse that arrives while a probe is running is ignored. It adds no bus cycle and no extra `done`.
- R11: The write and read strobes are never high together. After reset the strobes and `done` are low and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to probe the bank |
| done | output | 1 | One-cycle completion pulse |
| bus_addr | output | ADDR_W | Word address on the memory bus |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid the cycle after bus_re |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| family | output | 2 | 0 unknown, 1 unlock-cycle, 2 status-register |
| dev_type | output | 4 | Detected device type, 0 when unknown |
| size_bytes | output | 32 | Bank size in bytes |
| sect_count | output | 8 | Number of sectors |
| sect_idx | input | 8 | Sector index for the address lookup |
| sect_addr | output | 32 | Start address of sector sect_idx |

## Verification
The bench puts garbage in the upper bytes of the manufacturer word. A design that decoded the whole word would then report an unknown part. It also feeds a device word whose two lanes differ, which a design comparing only one lane would accept. The sector lookup is probed on both sides of the boot/main boundary (indices 7 and 8), at the last sector and one past it, where an off-by-one in the (i−7) offset or in the range test shows up as a wrong address. The bench also fires a second start during the wait, times the gap between the command write and the first read, and checks that an unknown part gets no read-mode write at all.

// File: rtl/nor_id_probe.sv
module nor_id_probe #(
  parameter int          ADDR_W     = 22,
  parameter int          DATA_W     = 32,
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          WAIT_US    = 100,
  parameter logic [31:0] BANK_BASE  = 32'h0,
  parameter logic [7:0]  MAN_UNLOCK = 8'h01,
  parameter logic [7:0]  MAN_STATUS = 8'h89,
  parameter logic [15:0] ID_UNI     = 16'h22D7,
  parameter logic [15:0] ID_C8      = 16'h88C1,
  parameter logic [15:0] ID_C16     = 16'h88C3,
  parameter logic [15:0] ID_C32     = 16'h88C5,
  parameter logic [15:0] ID_C64     = 16'h88CD,
  parameter logic [15:0] ID_B8      = 16'h8892,
  parameter logic [15:0] ID_B16     = 16'h8894,
  parameter logic [15:0] ID_B32     = 16'h8896,
  parameter logic [15:0] ID_B64     = 16'h8898
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic [1:0]        family,
  output logic [3:0]        dev_type,
  output logic [31:0]       size_bytes,
  output logic [7:0]        sect_count,
  input  logic [7:0]        sect_idx,
  output logic [31:0]       sect_addr
);

  localparam int          LANES     = DATA_W / 16;
  localparam int          WAIT_CYC  = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int          CNT_W     = $clog2(WAIT_CYC + 1);
  localparam logic [31:0] BOOT_UNIT = 32'(32'h2000 * LANES);
  localparam logic [31:0] MAIN_UNIT = 32'(32'h10000 * LANES);
  localparam logic [31:0] MB_UNIT   = 32'(32'h100000 * LANES);

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_UNL1 = 4'd1, S_UNL2 = 4'd2, S_CMD  = 4'd3,
    S_WAIT = 4'd4, S_RMAN = 4'd5, S_CMAN = 4'd6, S_RDEV = 4'd7,
    S_CDEV = 4'd8, S_EXIT = 4'd9, S_DONE = 4'd10
  } state_t;

  state_t           state, nxt;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       man_fam, man_dec, fam_q;
  logic [3:0]       dev_dec, typ_q;
  logic [7:0]       mb;
  logic [31:0]      off;
  logic             known;

  function automatic logic [DATA_W-1:0] lanes(input logic [7:0] b);
    return {LANES{8'h00, b}};
  endfunction

  function automatic logic [DATA_W-1:0] wide(input logic [15:0] c);
    return {LANES{c}};
  endfunction

  always_comb begin
    if (bus_rdata[7:0] == MAN_UNLOCK)      man_dec = 2'd1;
    else if (bus_rdata[7:0] == MAN_STATUS) man_dec = 2'd2;
    else                                   man_dec = 2'd0;
  end

  always_comb begin
    if      (bus_rdata == wide(ID_UNI)) dev_dec = 4'd1;
    else if (bus_rdata == wide(ID_C8))  dev_dec = 4'd2;
    else if (bus_rdata == wide(ID_C16)) dev_dec = 4'd3;
    else if (bus_rdata == wide(ID_C32)) dev_dec = 4'd4;
    else if (bus_rdata == wide(ID_C64)) dev_dec = 4'd5;
    else if (bus_rdata == wide(ID_B8))  dev_dec = 4'd6;
    else if (bus_rdata == wide(ID_B16)) dev_dec = 4'd7;
    else if (bus_rdata == wide(ID_B32)) dev_dec = 4'd8;
    else if (bus_rdata == wide(ID_B64)) dev_dec = 4'd9;
    else                                dev_dec = 4'd0;
  end

  assign known = (man_fam != 2'd0) && (dev_dec != 4'd0);

  always_comb begin
    case (state)
      S_IDLE:  nxt = start ? S_UNL1 : S_IDLE;
      S_UNL1:  nxt = S_UNL2;
      S_UNL2:  nxt = S_CMD;
      S_CMD:   nxt = S_WAIT;
      S_WAIT:  nxt = (cnt == '0) ? S_RMAN : S_WAIT;
      S_RMAN:  nxt = S_CMAN;
      S_CMAN:  nxt = S_RDEV;
      S_RDEV:  nxt = S_CDEV;
      S_CDEV:  nxt = known ? S_EXIT : S_DONE;
      S_EXIT:  nxt = S_DONE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      man_fam <= 2'd0;
      fam_q   <= 2'd0;
      typ_q   <= 4'd0;
    end else begin
      state <= nxt;
      if (state == S_CMD)       cnt <= CNT_W'(WAIT_CYC - 1);
      else if (state == S_WAIT) cnt <= cnt - 1'b1;
      if (state == S_IDLE && start) begin
        fam_q <= 2'd0;
        typ_q <= 4'd0;
      end
      if (state == S_CMAN) man_fam <= man_dec;
      if (state == S_CDEV && known) begin
        fam_q <= man_fam;
        typ_q <= dev_dec;
      end
    end
  end

  assign bus_we = (state == S_UNL1) || (state == S_UNL2) ||
                  (state == S_CMD)  || (state == S_EXIT);
  assign bus_re = (state == S_RMAN) || (state == S_RDEV);
  assign done   = (state == S_DONE);

  always_comb begin
    case (state)
      S_UNL1, S_CMD: bus_addr = ADDR_W'(11'h555);
      S_UNL2:        bus_addr = ADDR_W'(11'h2AA);
      S_RDEV:        bus_addr = ADDR_W'(1);
      default:       bus_addr = '0;
    endcase
  end

  always_comb begin
    case (state)
      S_UNL1:  bus_wdata = lanes(8'hAA);
      S_UNL2:  bus_wdata = lanes(8'h55);
      S_CMD:   bus_wdata = lanes(8'h90);
      S_EXIT:  bus_wdata = (fam_q == 2'd2) ? lanes(8'hFF) : lanes(8'hF0);
      default: bus_wdata = '0;
    endcase
  end

  always_comb begin
    case (typ_q)
      4'd1:       begin sect_count = 8'd128; mb = 8'd8; end
      4'd2, 4'd6: begin sect_count = 8'd23;  mb = 8'd1; end
      4'd3, 4'd7: begin sect_count = 8'd39;  mb = 8'd2; end
      4'd4, 4'd8: begin sect_count = 8'd71;  mb = 8'd4; end
      4'd5, 4'd9: begin sect_count = 8'd135; mb = 8'd8; end
      default:    begin sect_count = 8'd0;   mb = 8'd0; end
    endcase
  end

  assign size_bytes = 32'(mb) * MB_UNIT;
  assign family     = fam_q;
  assign dev_type   = typ_q;

  always_comb begin
    if (typ_q >= 4'd2 && sect_idx >= 8'd8) off = 32'(sect_idx - 8'd7) * MAIN_UNIT;
    else if (typ_q >= 4'd2)                off = 32'(sect_idx) * BOOT_UNIT;
    else                                   off = 32'(sect_idx) * MAIN_UNIT;
  end

  assign sect_addr = (sect_idx < sect_count) ? BANK_BASE + off : 32'h0;

endmodule

// File: rtl/nor_id_probe_chk.sv
module nor_id_probe_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [1:0]        family,
  input logic [3:0]        dev_type,
  input logic [31:0]       size_bytes,
  input logic [7:0]        sect_count,
  input logic [3:0]        st
);
  localparam int LANES = DATA_W / 16;
  localparam logic [DATA_W-1:0] RD_F0 = {LANES{16'h00F0}};
  localparam logic [DATA_W-1:0] RD_FF = {LANES{16'h00FF}};

  // R11
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  // R1
  unlock_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wdata[7:0] == 8'hAA) |=>
      (bus_we && bus_addr == ADDR_W'(11'h2AA) && bus_wdata[7:0] == 8'h55));

  // R2 (state 4 is the wait phase)
  quiet_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd4) |-> (!bus_we && !bus_re));

  // R5
  unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && family == 2'd0) |-> (dev_type == 4'd0 && size_bytes == 32'h0 && sect_count == 8'd0));

  // R6
  known_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && family != 2'd0) |-> (sect_count != 8'd0 && size_bytes != 32'h0));

  // R8
  exit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0) |-> (bus_wdata == RD_F0 || bus_wdata == RD_FF));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0 && !start) |=> ($stable(family) && $stable(dev_type)));

  // R10 (state 1 is entered only from idle)
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 4'd0 && start) |=> (st != 4'd1));
endmodule

bind nor_id_probe nor_id_probe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .family(family), .dev_type(dev_type), .size_bytes(size_bytes),
  .sect_count(sect_count), .st(state)
);

// File: tb/nor_id_probe_bench.sv
module nor_id_probe_bench;
  localparam int          ADDR_W   = 22;
  localparam int          DATA_W   = 32;
  localparam int          CLK_HZ   = 50_000_000;
  localparam int          WAIT_US  = 100;
  localparam logic [31:0] BASE     = 32'h1000_0000;
  localparam int          WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;

  typedef struct packed {
    logic [31:0] man;
    logic [31:0] dev;
    logic [1:0]  fam;
    logic [3:0]  typ;
    logic [7:0]  cnt;
    logic [31:0] sz;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0001, 32'h22D7_22D7, 2'd1, 4'd1, 8'd128, 32'h0100_0000},
    '{32'h0089_0089, 32'h88C1_88C1, 2'd2, 4'd2, 8'd23,  32'h0020_0000},
    '{32'h1234_0089, 32'h88C3_88C3, 2'd2, 4'd3, 8'd39,  32'h0040_0000},
    '{32'h0000_0089, 32'h88C5_88C5, 2'd2, 4'd4, 8'd71,  32'h0080_0000},
    '{32'h0000_0089, 32'h88CD_88CD, 2'd2, 4'd5, 8'd135, 32'h0100_0000},
    '{32'h0000_0089, 32'h8892_8892, 2'd2, 4'd6, 8'd23,  32'h0020_0000},
    '{32'h0000_0089, 32'h8894_8894, 2'd2, 4'd7, 8'd39,  32'h0040_0000},
    '{32'h0000_0089, 32'h8896_8896, 2'd2, 4'd8, 8'd71,  32'h0080_0000},
    '{32'h0000_0089, 32'h8898_8898, 2'd2, 4'd9, 8'd135, 32'h0100_0000},
    '{32'h0000_00C2, 32'h22D7_22D7, 2'd0, 4'd0, 8'd0,   32'h0},
    '{32'h0000_0001, 32'h22D7_88C1, 2'd0, 4'd0, 8'd0,   32'h0},
    '{32'h0000_0001, 32'h88CD_88CD, 2'd1, 4'd5, 8'd135, 32'h0100_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, bus_we, bus_re;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic [1:0]  family;
  logic [3:0]  dev_type;
  logic [31:0] size_bytes, sect_addr;
  logic [7:0]  sect_count;
  logic [7:0]  sect_idx = 8'd0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nor_id_probe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_HZ(CLK_HZ),
                 .WAIT_US(WAIT_US), .BANK_BASE(BASE)) u_nor_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_we(bus_we), .bus_re(bus_re), .family(family), .dev_type(dev_type),
    .size_bytes(size_bytes), .sect_count(sect_count),
    .sect_idx(sect_idx), .sect_addr(sect_addr)
  );

  logic [31:0] man_w = '0, dev_w = '0;
  logic        idm = 1'b0;
  int cyc = 0, wn = 0, rn = 0, dn = 0;
  logic [ADDR_W-1:0] wa [16];
  logic [DATA_W-1:0] wd [16];
  int wc [16];
  int rc [16];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) dn <= dn + 1;
    if (bus_we) begin
      wa[wn[3:0]] <= bus_addr;
      wd[wn[3:0]] <= bus_wdata;
      wc[wn[3:0]] <= cyc;
      wn <= wn + 1;
      if (bus_wdata[7:0] == 8'h90) idm <= 1'b1;
      else if (bus_wdata[7:0] == 8'hF0 || bus_wdata[7:0] == 8'hFF) idm <= 1'b0;
    end
    if (bus_re) begin
      rc[rn[3:0]] <= cyc;
      rn <= rn + 1;
      if (!idm)               bus_rdata <= '1;
      else if (bus_addr == 0) bus_rdata <= man_w;
      else if (bus_addr == 1) bus_rdata <= dev_w;
      else                    bus_rdata <= '0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  int bw, br, bd;

  task automatic probe(input logic [31:0] m, input logic [31:0] d);
    man_w = m;
    dev_w = d;
    bw = wn;
    br = rn;
    bd = dn;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R9 results cleared on start", {30'd0, family}, 32'd0);
    while (!done) @(negedge clk);
  endtask

  task automatic sect(input logic [7:0] idx, input logic [31:0] exp, input string req);
    sect_idx = idx;
    #1;
    chk(req, sect_addr, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual 0x0 expected 0x1 (done never completed)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R11 reset strobes", {30'd0, bus_we, bus_re}, 32'd0);
    chk("R11 reset family", {30'd0, family}, 32'd0);
    chk("R11 reset size", size_bytes, 32'd0);
    chk("R11 reset count", {24'd0, sect_count}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      probe(VEC[i].man, VEC[i].dev);
      chk("R3 family", {30'd0, family}, {30'd0, VEC[i].fam});
      chk("R4 type", {28'd0, dev_type}, {28'd0, VEC[i].typ});
      chk("R6 sector count", {24'd0, sect_count}, {24'd0, VEC[i].cnt});
      chk("R6 size", size_bytes, VEC[i].sz);
      chk("R2 wait gap", rc[br[3:0]] - wc[(bw + 2) % 16], WAIT_CYC + 1);
      if (VEC[i].fam == 2'd0) begin
        chk("R5 no exit write", wn - bw, 3);
      end else begin
        chk("R8 write count", wn - bw, 4);
        chk("R8 exit address", 32'(wa[(bw + 3) % 16]), 32'd0);
        chk("R8 exit data", wd[(bw + 3) % 16],
            (VEC[i].fam == 2'd1) ? 32'h00F0_00F0 : 32'h00FF_00FF);
        chk("R9 done after exit", cyc - wc[(bw + 3) % 16], 1);
      end
      if (i == 0) begin
        chk("R1 first addr", 32'(wa[bw % 16]), 32'h555);
        chk("R1 first data", wd[bw % 16], 32'h00AA_00AA);
        chk("R1 second addr", 32'(wa[(bw + 1) % 16]), 32'h2AA);
        chk("R1 second data", wd[(bw + 1) % 16], 32'h0055_0055);
        chk("R1 third addr", 32'(wa[(bw + 2) % 16]), 32'h555);
        chk("R1 third data", wd[(bw + 2) % 16], 32'h0090_0090);
        chk("R1 consecutive", wc[(bw + 2) % 16] - wc[bw % 16], 2);
        sect(8'd0,   BASE,                 "R7 uniform idx0");
        sect(8'd1,   BASE + 32'h0002_0000, "R7 uniform idx1");
        sect(8'd127, BASE + 32'h00FE_0000, "R7 uniform last");
        sect(8'd128, 32'h0,                "R7 uniform past end");
      end
      if (i == 8) begin
        sect(8'd1,   BASE + 32'h0000_4000, "R7 boot idx1");
        sect(8'd7,   BASE + 32'h0001_C000, "R7 boot idx7");
        sect(8'd8,   BASE + 32'h0002_0000, "R7 boot idx8");
        sect(8'd134, BASE + 32'h00FE_0000, "R7 boot last");
        sect(8'd135, 32'h0,                "R7 boot past end");
      end
      if (i == 9) sect(8'd0, 32'h0, "R7 unknown lookup");
      @(negedge clk);
      chk("R9 done one cycle", {31'd0, done}, 32'd0);
      chk("R9 single done", dn - bd, 1);
    end

    // R9 results held while idle
    probe(32'h89, 32'h88C3_88C3);
    bw = wn;
    repeat (20) @(negedge clk);
    chk("R9 hold type", {28'd0, dev_type}, 32'd3);
    chk("R9 hold size", size_bytes, 32'h0040_0000);
    chk("R9 idle bus quiet", wn - bw, 0);

    // R10 second start mid-probe
    man_w = 32'h1;
    dev_w = 32'h22D7_22D7;
    bw = wn; br = rn; bd = dn;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R10 write count", wn - bw, 4);
    chk("R10 read count", rn - br, 2);
    chk("R10 done count", dn - bd, 1);
    chk("R10 result", {28'd0, dev_type}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule